// File: doc/BRIEF.md
# I2C Slave with Byte-Count and Stream Registers

This block is a fast-mode I2C target (SCL up to 400 kHz) that a host reaches through a 256-address, byte-wide register space. Both bus lines are oversampled on the system clock, so START, STOP and repeated START are decoded from the samples. The slave matches its programmable 7-bit address and takes a register pointer from the first data byte of a write. For reads, it drives SDA low through an open-drain enable. A producer fills an internal stream FIFO through a simple push port.

The top of the register space is special. Register 0xFF pops the next byte of the stream on every read, and returns 0xFF when the stream is empty. Registers 0xFD and 0xFE together report how many stream bytes are waiting. Every address below 0xFD reads as zero. The pointer advances after each byte that is read, and it stops advancing at 0xFF, so one long read drains the stream.

The bus controller has eight states. IDLE waits for a START. ADDR shifts in the address byte. AACK drives the address ACK. RX shifts in a written byte. RACK drives the ACK for a written byte. TX shifts out a read byte. TACK samples the master's ACK or NACK. SKIP ignores the bus until the next START or STOP.

The transitions are as follows:
- A STOP from any state leads to IDLE.
- A START or repeated START from any state leads to ADDR.
- ADDR goes to AACK on a match, or to SKIP on a mismatch, at the SCL fall after the eighth bit.
- AACK goes to TX (read) or RX (write) at the next fall.
- RX goes to RACK after eight bits.
- RACK returns to RX at the next fall.
- TX goes to TACK after eight falls.
- TACK goes to TX after an ACK, or to SKIP after a NACK.

Top module: `i2c_stream_slave`

## Requirements
- R1: The slave drives the ACK (SDA low) after an address byte only when bits [7:1] of that byte equal bits [7:1] of its address setting. Bit 0 of the byte is the R/W flag, with 1 meaning read. After reset the setting is 0x86, so 7-bit address 0x43 is the only one acknowledged.
- R2: A pulse on `cfg_we_i` loads `cfg_addr_i` as the new address setting, with the 7-bit address in bits [7:1]. From then on only the new address is acknowledged.
- R3: In a write transaction, the first data byte sets the register pointer. Every later data byte is acknowledged and discarded, and leaves both the pointer and the stream untouched.
- R4: Reads at pointer values 0x00 to 0xFC return 0x00.
- R5: Reading 0xFD captures the current stream count as a 16-bit snapshot and returns its upper byte. Reading 0xFE returns the lower byte of the most recent snapshot, which is 0 after reset.
- R6: Reading 0xFF removes and returns the oldest stream byte. When the stream is empty it returns 0xFF and removes nothing.
- R7: After each byte read the pointer increments if it is below 0xFF, and stays at 0xFF otherwise. The pointer is kept across transactions.
- R8: After a write that sets the pointer, a repeated START with a read address reads from that pointer.
- R9: After the master NACKs a read byte the slave keeps SDA released until the next START. A STOP returns it to IDLE with SDA released.
- R10: The stream holds 2^FIFO_AW bytes (16 by default). `fifo_full_o` is high when it is full, and pushes made while it is full are dropped.
- R11: The SDA drive enable changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open drain) |
| cfg_we_i | input | 1 | Load strobe for the address setting |
| cfg_addr_i | input | 8 | New address setting, 7-bit address in [7:1] |
| push_i | input | 1 | Push one byte into the stream |
| push_data_i | input | 8 | Byte to push |
| fifo_full_o | output | 1 | Stream buffer full |

## Verification
The assertions assume the following about the inputs:
- The master changes SDA only while SCL is low, except when it makes a START or STOP.
- Every SCL phase lasts several system clocks, so each edge passes the synchroniser before the next one arrives.
- The address setting is not reloaded while a transaction is in progress.

The bench models an open-drain bus. Its master holds every quarter bit for six clocks and moves SDA a full quarter after each SCL fall. It reprograms the address only while the bus is idle. The stream bytes it pushes never equal 0xFF.

// File: rtl/i2c_ss_pkg.sv
package i2c_ss_pkg;
    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_AACK, S_RX, S_RACK, S_TX, S_TACK, S_SKIP
    } bus_state_t;

    localparam logic [7:0] PTR_CNT_HI = 8'hFD;
    localparam logic [7:0] PTR_CNT_LO = 8'hFE;
    localparam logic [7:0] PTR_STREAM = 8'hFF;
    localparam logic [7:0] ADDR_RESET = 8'h86;
endpackage

// File: rtl/i2c_ss_sync.sv
module i2c_ss_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_o,
    output logic sda_o,
    output logic rise_o,
    output logic fall_o,
    output logic start_o,
    output logic stop_o
);
    logic [STAGES-1:0] scl_p, sda_p;
    logic              scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= '1;
            sda_p <= '1;
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_p <= {scl_p[STAGES-2:0], scl_i};
            sda_p <= {sda_p[STAGES-2:0], sda_i};
            scl_q <= scl_p[STAGES-1];
            sda_q <= sda_p[STAGES-1];
        end
    end

    assign scl_o   = scl_p[STAGES-1];
    assign sda_o   = sda_p[STAGES-1];
    assign rise_o  = scl_o & ~scl_q;
    assign fall_o  = ~scl_o & scl_q;
    assign start_o = scl_o & scl_q & sda_q & ~sda_o;
    assign stop_o  = scl_o & scl_q & ~sda_q & sda_o;
endmodule

// File: rtl/i2c_ss_fifo.sv
module i2c_ss_fifo #(
    parameter int W  = 8,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  logic [W-1:0]  data_i,
    input  logic          pop_i,
    output logic [W-1:0]  data_o,
    output logic [AW:0]   count_o,
    output logic          full_o,
    output logic          empty_o
);
    localparam int DEPTH = 1 << AW;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_q, rd_q;
    logic          do_push, do_pop;

    assign full_o  = (count_o == (AW+1)'(DEPTH));
    assign empty_o = (count_o == '0);
    assign do_push = push_i && !full_o;
    assign do_pop  = pop_i && !empty_o;
    assign data_o  = mem[rd_q];

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_q] <= data_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= '0;
            rd_q    <= '0;
            count_o <= '0;
        end else begin
            if (do_push) wr_q <= wr_q + 1'b1;
            if (do_pop)  rd_q <= rd_q + 1'b1;
            if (do_push && !do_pop)      count_o <= count_o + 1'b1;
            else if (do_pop && !do_push) count_o <= count_o - 1'b1;
        end
    end

    AST_POP_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) pop_i |-> !empty_o); // R6
    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n) count_o <= (AW+1)'(DEPTH)); // R10
    AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n) (full_o && !pop_i) |=> full_o && $stable(count_o)); // R10
endmodule

// File: rtl/i2c_ss_rdsel.sv
module i2c_ss_rdsel
    import i2c_ss_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [7:0]       ptr_i,
    input  logic [CNT_W-1:0] count_i,
    input  logic [7:0]       fifo_data_i,
    input  logic             fifo_empty_i,
    output logic [7:0]       byte_o,
    output logic             pop_o
);
    logic [CNT_W-1:0] snap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            snap_q <= '0;
        else if (load_i && ptr_i == PTR_CNT_HI) snap_q <= count_i;
    end

    always_comb begin
        unique case (ptr_i)
            PTR_CNT_HI: byte_o = count_i[15:8];
            PTR_CNT_LO: byte_o = snap_q[7:0];
            PTR_STREAM: byte_o = fifo_empty_i ? 8'hFF : fifo_data_i;
            default:    byte_o = 8'h00;
        endcase
    end

    assign pop_o = load_i && (ptr_i == PTR_STREAM) && !fifo_empty_i;

    AST_SNAP_ONLY_ON_HI: assert property (@(posedge clk) disable iff (!rst_n) !(load_i && ptr_i == PTR_CNT_HI) |=> $stable(snap_q)); // R5
endmodule

// File: rtl/i2c_stream_slave.sv
module i2c_stream_slave
    import i2c_ss_pkg::*;
#(
    parameter int FIFO_AW     = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       cfg_we_i,
    input  logic [7:0] cfg_addr_i,
    input  logic       push_i,
    input  logic [7:0] push_data_i,
    output logic       fifo_full_o
);
    localparam int CNT_W = 16;

    logic scl_s, sda_s, rise, fall, start_ev, stop_ev;
    bus_state_t state_q, state_d;
    logic [3:0] bitcnt_q;
    logic [7:0] shreg_q, txreg_q, ptr_q, addr_q;
    logic       rw_q, first_q, nack_q;
    logic       load_rd, set_ptr, addr_hit, pop;
    logic [7:0] rd_byte, fifo_dout;
    logic [FIFO_AW:0] fifo_cnt;
    logic       fifo_empty;
    logic       unused_rw_bit;

    i2c_ss_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_o(scl_s), .sda_o(sda_s), .rise_o(rise), .fall_o(fall),
        .start_o(start_ev), .stop_o(stop_ev)
    );

    i2c_ss_fifo #(.W(8), .AW(FIFO_AW)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .data_i(push_data_i),
        .pop_i(pop), .data_o(fifo_dout), .count_o(fifo_cnt),
        .full_o(fifo_full_o), .empty_o(fifo_empty)
    );

    i2c_ss_rdsel #(.CNT_W(CNT_W)) u_rdsel (
        .clk(clk), .rst_n(rst_n), .load_i(load_rd), .ptr_i(ptr_q),
        .count_i(CNT_W'(fifo_cnt)), .fifo_data_i(fifo_dout),
        .fifo_empty_i(fifo_empty), .byte_o(rd_byte), .pop_o(pop)
    );

    assign addr_hit      = (shreg_q[7:1] == addr_q[7:1]);
    assign unused_rw_bit = addr_q[0];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Next state and control strobes
    always_comb begin
        state_d = state_q;
        load_rd = 1'b0;
        set_ptr = 1'b0;
        if (stop_ev) begin
            state_d = S_IDLE;
        end else if (start_ev) begin
            state_d = S_ADDR;
        end else begin
            unique case (state_q)
                S_IDLE, S_SKIP: ;
                S_ADDR: if (fall && bitcnt_q == 4'd8) state_d = addr_hit ? S_AACK : S_SKIP;
                S_AACK: if (fall) begin
                    if (rw_q) begin
                        state_d = S_TX;
                        load_rd = 1'b1;
                    end else begin
                        state_d = S_RX;
                    end
                end
                S_RX: if (fall && bitcnt_q == 4'd8) begin
                    state_d = S_RACK;
                    set_ptr = first_q;
                end
                S_RACK: if (fall) state_d = S_RX;
                S_TX:   if (fall && bitcnt_q == 4'd7) state_d = S_TACK;
                S_TACK: if (fall) begin
                    if (nack_q) begin
                        state_d = S_SKIP;
                    end else begin
                        state_d = S_TX;
                        load_rd = 1'b1;
                    end
                end
                default: state_d = S_IDLE;
            endcase
        end
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt_q <= '0;
            shreg_q  <= '0;
            txreg_q  <= '0;
            ptr_q    <= '0;
            addr_q   <= ADDR_RESET;
            rw_q     <= 1'b0;
            first_q  <= 1'b0;
            nack_q   <= 1'b0;
        end else begin
            if (cfg_we_i) addr_q <= cfg_addr_i;
            if (start_ev) first_q <= 1'b1;
            else if (state_q == S_RX && state_d == S_RACK) first_q <= 1'b0;

            if (start_ev || state_q != state_d) bitcnt_q <= '0;
            else if (rise && (state_q == S_ADDR || state_q == S_RX)) bitcnt_q <= bitcnt_q + 1'b1;
            else if (fall && state_q == S_TX) bitcnt_q <= bitcnt_q + 1'b1;

            if (rise && (state_q == S_ADDR || state_q == S_RX)) shreg_q <= {shreg_q[6:0], sda_s};
            if (state_q == S_ADDR && state_d == S_AACK) rw_q <= shreg_q[0];
            if (rise && state_q == S_TACK) nack_q <= sda_s;

            if (load_rd) txreg_q <= rd_byte;
            else if (fall && state_q == S_TX) txreg_q <= {txreg_q[6:0], 1'b0};

            if (set_ptr) ptr_q <= shreg_q;
            else if (load_rd && ptr_q != PTR_STREAM) ptr_q <= ptr_q + 1'b1;
        end
    end

    // Outputs
    always_comb begin
        unique case (state_q)
            S_AACK, S_RACK: sda_oe_o = 1'b1;
            S_TX:           sda_oe_o = ~txreg_q[7];
            default:        sda_oe_o = 1'b0;
        endcase
    end

    AST_SDA_MOVES_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) ($rose(sda_oe_o) || $fell(sda_oe_o)) |-> !scl_s); // R11
    AST_ACK_ONLY_ON_MATCH: assert property (@(posedge clk) disable iff (!rst_n) $rose(state_q == S_AACK) |-> (shreg_q[7:1] == addr_q[7:1])); // R1
    AST_PTR_HOLDS_AT_TOP: assert property (@(posedge clk) disable iff (!rst_n) (ptr_q == PTR_STREAM && !set_ptr) |=> ptr_q == PTR_STREAM); // R7
    AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n) stop_ev |=> (state_q == S_IDLE) && !sda_oe_o); // R9
    AST_POP_ON_STREAM_LOAD: assert property (@(posedge clk) disable iff (!rst_n) pop |-> (ptr_q == PTR_STREAM) && (state_q == S_AACK || state_q == S_TACK)); // R6
endmodule

// File: tb/tb_i2c_stream_slave.sv
module tb_i2c_stream_slave;
    localparam int Q = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_bus;
    logic cfg_we = 1'b0;
    logic [7:0] cfg_addr = 8'h00;
    logic push = 1'b0;
    logic [7:0] push_data = 8'h00;
    logic fifo_full;

    int checks = 0;
    int failures = 0;
    logic done = 1'b0;

    logic [7:0] mq[$];
    int mptr = 0;
    int msnap = 0;

    always #2.5 clk = ~clk;
    assign sda_bus = !(sda_oe || m_low);

    i2c_stream_slave dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
        .sda_oe_o(sda_oe), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
        .push_i(push), .push_data_i(push_data), .fifo_full_o(fifo_full)
    );

    task automatic chk(input logic ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start();
        m_low = 1'b0; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b1; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic i2c_stop();
        m_low = 1'b1; wq(Q); scl = 1'b1; wq(Q); m_low = 1'b0; wq(Q);
    endtask

    task automatic bit_xfer(input logic b, output logic s);
        m_low = ~b; wq(Q); scl = 1'b1; wq(Q); s = sda_bus; wq(Q); scl = 1'b0; wq(Q);
    endtask

    task automatic wbyte(input logic [7:0] v, output logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], s);
        bit_xfer(1'b1, s);
        ack = ~s;
    endtask

    task automatic rbyte(output logic [7:0] v, input logic ack);
        logic s;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, s);
            v[i] = s;
        end
        bit_xfer(~ack, s);
    endtask

    task automatic do_push(input logic [7:0] v);
        @(negedge clk); push = 1'b1; push_data = v;
        @(negedge clk); push = 1'b0;
        if (mq.size() < 16) mq.push_back(v);
    endtask

    function automatic int model_read();
        int e;
        if (mptr < 253) e = 0;
        else if (mptr == 253) begin msnap = mq.size(); e = (msnap >> 8) & 255; end
        else if (mptr == 254) e = msnap & 255;
        else e = (mq.size() > 0) ? int'(mq.pop_front()) : 255;
        if (mptr < 255) mptr++;
        return e;
    endfunction

    task automatic set_ptr(input logic [7:0] p, input string req);
        logic a;
        i2c_start();
        wbyte(8'h86, a); chk(a, req, a, 1);
        wbyte(p, a);     chk(a, req, a, 1);
        mptr = p;
    endtask

    task automatic read_n(input int n, input string req);
        logic a;
        logic [7:0] v;
        int e;
        i2c_start();
        wbyte(8'h87, a); chk(a, req, a, 1);
        for (int k = 0; k < n; k++) begin
            rbyte(v, k != n - 1);
            e = model_read();
            chk(v == 8'(e), req, v, e);
        end
        chk(!sda_oe, "R9 SDA released after NACK", sda_oe, 0);
        i2c_stop();
    endtask

    task automatic probe(input logic [6:0] a7, input logic exp, input string req);
        logic a;
        i2c_start();
        wbyte({a7, 1'b0}, a);
        i2c_stop();
        chk(a == exp, req, a, exp);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic a;
        wq(10);
        rst_n = 1'b1;
        wq(5);
        chk(!sda_oe, "R9 SDA released at reset", sda_oe, 0);
        chk(!fifo_full, "R10 not full at reset", fifo_full, 0);

        // R1: sweep all 7-bit addresses against reset setting 0x86
        for (int a7 = 0; a7 < 128; a7++) probe(7'(a7), a7 == 'h43, "R1 address match");
        chk(!sda_oe, "R9 idle after STOP", sda_oe, 0);

        // R2: reprogram to 7-bit 0x20, then restore
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'h40; @(negedge clk); cfg_we = 1'b0;
        probe(7'h20, 1'b1, "R2 new address acked");
        probe(7'h43, 1'b0, "R2 old address ignored");
        @(negedge clk); cfg_we = 1'b1; cfg_addr = 8'h86; @(negedge clk); cfg_we = 1'b0;

        // R4 R5 R6 R7 R8: full pointer sweep through a repeated START
        for (int i = 0; i < 5; i++) do_push(8'(8'h11 + i * 3));
        set_ptr(8'h00, "R8 pointer write");
        read_n(262, "R4 R5 R6 R7 sweep read");

        // R5: stale snapshot at 0xFE
        set_ptr(8'hFD, "R5 pointer write");
        read_n(1, "R5 high byte");
        for (int i = 0; i < 3; i++) do_push(8'(8'h40 + i));
        read_n(1, "R5 low byte of earlier snapshot");
        read_n(1, "R6 R7 pointer kept, pop");

        // R3: extra write bytes discarded
        set_ptr(8'hFC, "R3 pointer write");
        wbyte(8'hFF, a); chk(a, "R3 extra byte acked", a, 1);
        wbyte(8'h00, a); chk(a, "R3 extra byte acked", a, 1);
        i2c_stop();
        read_n(3, "R3 pointer and stream untouched");
        read_n(3, "R6 drain then empty");

        // R10: overfill
        for (int i = 0; i < 20; i++) do_push(8'(i + 1));
        chk(fifo_full, "R10 full flag", fifo_full, 1);
        set_ptr(8'hFD, "R10 pointer write");
        read_n(3, "R10 count saturates at depth");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule